// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block recovers character framing from a serial bit stream on a byte-oriented synchronous link. After reset, or after a hunt command, it watches every accepted bit for a programmed sync pattern. When the pattern appears it raises a lock flag and emits a one-cycle detection pulse. From then on it stops comparing and cuts the stream into characters of a selectable length, presenting each one with a one-cycle valid strobe.

The pattern can be a single character (monosync) or two consecutive characters (bisync). The length can be 6, 8 or 16 bits. The first and second sync registers hold the characters. A bit is taken only on a cycle where the receive enable is high. Bits arrive least significant first, and the first bit of a pattern sits in bit 0 of its register.

Top module: `sync_hunt_top`

## Requirements
- R1: While reset is high, and after it is released, `sync_ok`, `sync_hit`, `rx_char_vld` are 0 and `rx_char` is 0.
- R2: With `sync_len`=1 (8-bit) and `bisync`=0, lock occurs on the clock edge that samples the bit completing a match of the last 8 accepted bits with `sync_b`, the earliest of those bits compared with bit 0. On that edge `sync_ok` goes to 1 and `sync_hit` is 1 for exactly one cycle.
- R3: With `sync_len`=0 (6-bit) and `bisync`=0, the last 6 accepted bits are compared with `sync_b[5:0]`, and `sync_b[7:6]` has no effect.
- R4: With `sync_len`=2 (16-bit), the last 16 accepted bits are compared with {`sync_b`,`sync_a`}, so `sync_a` bit 0 is the earliest bit. `bisync` has no effect at this length.
- R5: With `sync_len`=1 and `bisync`=1, lock needs 8 bits equal to `sync_a`, immediately followed by 8 bits equal to `sync_b`. A correct first character alone does not lock.
- R6: With `sync_len`=0 and `bisync`=1, lock needs `sync_a[5:0]` followed by `sync_b[5:0]`, 12 bits in all.
- R7: Only bits accepted since the last reset or hunt command take part in a match. No lock is declared before the pattern length in bits has been accepted.
- R8: A cycle with `rx_en`=0 takes no bit: the lock state, the character count and `rx_char` are unchanged, and `rx_char_vld` is 0 on the next cycle.
- R9: After lock, each group of N accepted bits forms one character, with N = 5 + `char_sel` (0..3 gives 5..8). Counting starts with the first bit after the sync pattern. On the edge of the Nth bit, `rx_char` takes the group with its first bit in bit 0 and its unused upper bits at 0, and `rx_char_vld` is 1 for one cycle.
- R10: While locked, no comparison is made: a sync pattern in the data raises no `sync_hit`.
- R11: `hunt_cmd`=1 clears `sync_ok` on that edge, discards any bit offered in the same cycle, and restarts the search with the next accepted bit.
- R12: `sync_len`=3 behaves exactly as `sync_len`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Takes `rx_bit` on this cycle |
| rx_bit | input | 1 | Serial data bit |
| hunt_cmd | input | 1 | Drop lock and restart the search |
| bisync | input | 1 | 0: one sync character, 1: two consecutive characters |
| sync_len | input | 2 | 0: 6-bit, 1: 8-bit, 2: 16-bit, 3: as 1 |
| sync_a | input | 8 | First sync character (low half of 16-bit pattern) |
| sync_b | input | 8 | Second sync character (monosync pattern) |
| char_sel | input | 2 | Character length after lock, 5 + value bits |
| sync_ok | output | 1 | Lock achieved |
| sync_hit | output | 1 | One-cycle pulse on the locking edge |
| rx_char | output | 8 | Last assembled character |
| rx_char_vld | output | 1 | One-cycle strobe with a new `rx_char` |

## Verification
The bench uses the default parameters: 8-bit sync registers, a 6-bit short pattern and 8-bit characters. These defaults give every length code, both modes and all four character lengths. Each vector places the pattern at a known offset behind junk bits and checks that lock lands on exactly that bit. A zero pattern fed with zero bits tests that a partly filled history cannot match early. Directed runs then cover character cutting with idle gaps, sync patterns hidden in data while locked, and a hunt issued together with a valid bit.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'd0,
    LEN_BYTE  = 2'd1,
    LEN_LONG  = 2'd2,
    LEN_ALT   = 2'd3
  } sync_len_e;

endpackage

// File: rtl/sync_hunt_hist.sv
module sync_hunt_hist #(
  parameter int HIST_W = 16,
  localparam int FILL_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              shift_en,
  input  logic              din,
  output logic [HIST_W-1:0] hist_nx,
  output logic [FILL_W-1:0] fill_nx
);

  logic [HIST_W-1:0] hist_q;
  logic [FILL_W-1:0] fill_q;

  // newest bit enters at the top, so a window reads earliest-bit-low
  always_comb begin
    hist_nx = {din, hist_q[HIST_W-1:1]};
    if (restart)
      fill_nx = '0;
    else if (fill_q == FILL_W'(HIST_W))
      fill_nx = fill_q;
    else
      fill_nx = fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (restart) begin
      fill_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_nx;
      fill_q <= fill_nx;
    end
  end

endmodule

// File: rtl/sync_hunt_match.sv
module sync_hunt_match
  import sync_hunt_pkg::*;
#(
  parameter int SYNC_W  = 8,
  parameter int SHORT_W = 6,
  localparam int HIST_W = 2 * SYNC_W,
  localparam int FILL_W = $clog2(HIST_W + 1)
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [FILL_W-1:0] fill,
  input  logic              bisync,
  input  logic [1:0]        sync_len,
  input  logic [SYNC_W-1:0] sync_a,
  input  logic [SYNC_W-1:0] sync_b,
  output logic              match
);

  logic [SHORT_W-1:0] win_s_hi, win_s_lo;
  logic [SYNC_W-1:0]  win_b_hi, win_b_lo;
  logic               eq_mono_s, eq_bi_s, eq_mono_b, eq_bi_b, eq_long;
  sync_len_e          len;

  assign len      = sync_len_e'(sync_len);
  assign win_s_hi = hist[HIST_W-1 -: SHORT_W];
  assign win_s_lo = hist[HIST_W-1-SHORT_W -: SHORT_W];
  assign win_b_hi = hist[HIST_W-1 -: SYNC_W];
  assign win_b_lo = hist[SYNC_W-1:0];

  always_comb begin
    eq_mono_s = (win_s_hi == sync_b[SHORT_W-1:0]) && (fill >= FILL_W'(SHORT_W));
    eq_bi_s   = (win_s_hi == sync_b[SHORT_W-1:0]) && (win_s_lo == sync_a[SHORT_W-1:0])
                && (fill >= FILL_W'(2 * SHORT_W));
    eq_mono_b = (win_b_hi == sync_b) && (fill >= FILL_W'(SYNC_W));
    eq_bi_b   = (win_b_hi == sync_b) && (win_b_lo == sync_a) && (fill >= FILL_W'(HIST_W));
    eq_long   = (hist == {sync_b, sync_a}) && (fill >= FILL_W'(HIST_W));
    unique case (len)
      LEN_SHORT:         match = bisync ? eq_bi_s : eq_mono_s;
      LEN_LONG:          match = eq_long;
      LEN_BYTE, LEN_ALT: match = bisync ? eq_bi_b : eq_mono_b;
      default:           match = 1'b0;
    endcase
  end

endmodule

// File: rtl/sync_hunt_deframe.sv
module sync_hunt_deframe #(
  parameter int CHAR_W = 8,
  localparam int CNT_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              bit_en,
  input  logic              din,
  input  logic [1:0]        char_sel,
  output logic [CHAR_W-1:0] char_q,
  output logic              char_vld
);

  logic [CHAR_W-1:0] asm_q, asm_nx;
  logic [CNT_W-1:0]  cnt_q, last_idx;

  // shortest character is CHAR_W-3 bits
  assign last_idx = CNT_W'(CHAR_W - 4) + CNT_W'(char_sel);

  always_comb begin
    asm_nx        = asm_q;
    asm_nx[cnt_q] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asm_q    <= '0;
      cnt_q    <= '0;
      char_q   <= '0;
      char_vld <= 1'b0;
    end else begin
      char_vld <= 1'b0;
      if (restart) begin
        asm_q <= '0;
        cnt_q <= '0;
      end else if (bit_en) begin
        if (cnt_q >= last_idx) begin
          char_q   <= asm_nx;
          char_vld <= 1'b1;
          asm_q    <= '0;
          cnt_q    <= '0;
        end else begin
          asm_q <= asm_nx;
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sync_hunt_top.sv
module sync_hunt_top #(
  parameter int SYNC_W  = 8,
  parameter int SHORT_W = 6,
  parameter int CHAR_W  = 8,
  localparam int HIST_W = 2 * SYNC_W,
  localparam int FILL_W = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rx_bit,
  input  logic              hunt_cmd,
  input  logic              bisync,
  input  logic [1:0]        sync_len,
  input  logic [SYNC_W-1:0] sync_a,
  input  logic [SYNC_W-1:0] sync_b,
  input  logic [1:0]        char_sel,
  output logic              sync_ok,
  output logic              sync_hit,
  output logic [CHAR_W-1:0] rx_char,
  output logic              rx_char_vld
);

  logic              take;
  logic              hunting_bit;
  logic              locked_bit;
  logic              match;
  logic              hit_c;
  logic [HIST_W-1:0] hist_nx;
  logic [FILL_W-1:0] fill_nx;

  assign take        = rx_en && !hunt_cmd;
  assign hunting_bit = take && !sync_ok;
  assign locked_bit  = take && sync_ok;
  assign hit_c       = hunting_bit && match;

  sync_hunt_hist #(.HIST_W(HIST_W)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .restart (hunt_cmd),
    .shift_en(hunting_bit),
    .din     (rx_bit),
    .hist_nx (hist_nx),
    .fill_nx (fill_nx)
  );

  sync_hunt_match #(.SYNC_W(SYNC_W), .SHORT_W(SHORT_W)) u_match (
    .hist    (hist_nx),
    .fill    (fill_nx),
    .bisync  (bisync),
    .sync_len(sync_len),
    .sync_a  (sync_a),
    .sync_b  (sync_b),
    .match   (match)
  );

  sync_hunt_deframe #(.CHAR_W(CHAR_W)) u_defr (
    .clk     (clk),
    .rst     (rst),
    .restart (hit_c || hunt_cmd),
    .bit_en  (locked_bit),
    .din     (rx_bit),
    .char_sel(char_sel),
    .char_q  (rx_char),
    .char_vld(rx_char_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_ok  <= 1'b0;
      sync_hit <= 1'b0;
    end else begin
      sync_hit <= hit_c;
      if (hunt_cmd)
        sync_ok <= 1'b0;
      else if (hit_c)
        sync_ok <= 1'b1;
    end
  end

endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic hunt_cmd,
  input logic sync_ok,
  input logic sync_hit,
  input logic rx_char_vld
);

  // R2
  hit_sets_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sync_hit |-> sync_ok);

  // R2
  hit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> !sync_hit);

  // R10
  no_hit_while_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_ok && !hunt_cmd) |=> !sync_hit);

  // R9
  vld_only_locked_chk: assert property (@(posedge clk) disable iff (rst)
    rx_char_vld |-> sync_ok);

  // R11
  hunt_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
    hunt_cmd |=> !sync_ok);

  // R8
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !hunt_cmd) |=> ($stable(sync_ok) && !rx_char_vld && !sync_hit));

endmodule

bind sync_hunt_top sync_hunt_chk u_chk (.*);

// File: tb/sim_sync_hunt_top.sv
module sim_sync_hunt_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, rx_bit = 1'b0, hunt_cmd = 1'b0, bisync = 1'b0;
  logic [1:0] sync_len = 2'd1, char_sel = 2'd3;
  logic [7:0] sync_a = '0, sync_b = '0;
  logic       sync_ok, sync_hit, rx_char_vld;
  logic [7:0] rx_char;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sync_hunt_top u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        bis;
    logic [1:0]  len;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [31:0] stream;
    logic [5:0]  nb;
    logic [5:0]  ex;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b0, 2'd1, 8'h00, 8'h16, 32'h000000B5, 6'd16, 6'd11}, // R2
    '{4'd3,  1'b0, 2'd0, 8'h00, 8'hE5, 32'h00000097, 6'd12, 6'd8 }, // R3
    '{4'd4,  1'b0, 2'd2, 8'h3C, 8'hA5, 32'h00014A79, 6'd20, 6'd17}, // R4
    '{4'd5,  1'b1, 2'd1, 8'h32, 8'h99, 32'h000264CA, 6'd20, 6'd18}, // R5
    '{4'd6,  1'b1, 2'd0, 8'h0F, 8'h2A, 32'h00000A8F, 6'd14, 6'd12}, // R6
    '{4'd5,  1'b1, 2'd1, 8'h32, 8'h99, 32'h00000032, 6'd16, 6'd0 }, // R5 first char only
    '{4'd7,  1'b0, 2'd1, 8'h00, 8'h00, 32'h00000000, 6'd10, 6'd8 }, // R7
    '{4'd12, 1'b0, 2'd3, 8'h00, 8'h81, 32'h00000081, 6'd8,  6'd8 }, // R12
    '{4'd4,  1'b1, 2'd2, 8'h3C, 8'hA5, 32'h0000A53C, 6'd16, 6'd16}  // R4 mode ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns sampled outputs at the following negedge
  task automatic send_bit(input logic b, output logic hit, output logic vld);
    rx_en  = 1'b1;
    rx_bit = b;
    @(negedge clk);
    hit   = sync_hit;
    vld   = rx_char_vld;
    rx_en = 1'b0;
  endtask

  task automatic do_hunt();
    hunt_cmd = 1'b1;
    @(negedge clk);
    hunt_cmd = 1'b0;
  endtask

  // sends a character, checks strobe position and value
  task automatic send_char(input logic [7:0] v, input int n, input bit gaps, input string req);
    logic h, vl;
    int   vld_at = 0, hits = 0;
    for (int i = 0; i < n; i++) begin
      send_bit(v[i], h, vl);
      if (vl && vld_at == 0) vld_at = i + 1;
      if (h) hits++;
      if (gaps && i == 1) begin
        repeat (3) begin
          @(negedge clk);
          if (rx_char_vld) vld_at = 99;
        end
      end
    end
    check(vld_at == n, req, vld_at, n);
    check(rx_char == (v & 8'((1 << n) - 1)), req, rx_char, v & 8'((1 << n) - 1));
    check(hits == 0, "R10", hits, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic h, vl;
    int   first;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!sync_ok && !sync_hit && !rx_char_vld && rx_char == 0, "R1", sync_ok, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!sync_ok && !sync_hit && !rx_char_vld && rx_char == 0, "R1", sync_ok, 0);

    foreach (VEC[k]) begin
      bisync = VEC[k].bis; sync_len = VEC[k].len;
      sync_a = VEC[k].a;   sync_b = VEC[k].b;
      do_hunt();
      first = 0;
      for (int i = 1; i <= int'(VEC[k].nb); i++) begin
        send_bit(VEC[k].stream[i-1], h, vl);
        if (h && first == 0) first = i;
      end
      n_run++;
      if (first != int'(VEC[k].ex)) begin
        n_fail++;
        $display("FAIL R%0d vector %0d: lock bit actual %0d expected %0d",
                 VEC[k].req, k, first, VEC[k].ex);
      end
      check(sync_ok == (VEC[k].ex != 0), "R2 lock flag", sync_ok, VEC[k].ex != 0);
    end

    // R9/R10: lock on 0x16, then cut characters
    bisync = 1'b0; sync_len = 2'd1; sync_b = 8'h16;
    do_hunt();
    first = 0;
    for (int i = 1; i <= 8; i++) begin
      send_bit(sync_b[i-1], h, vl);
      if (h && first == 0) first = i;
    end
    check(first == 8, "R2", first, 8);
    char_sel = 2'd3;
    send_char(8'h16, 8, 1'b0, "R9 8-bit");
    char_sel = 2'd0;
    send_char(8'h13, 5, 1'b0, "R9 5-bit");
    char_sel = 2'd1;
    send_char(8'h2D, 6, 1'b1, "R8 gaps");
    char_sel = 2'd2;
    send_char(8'h6A, 7, 1'b0, "R9 7-bit");
    check(sync_ok == 1'b1, "R8", sync_ok, 1);

    // R11: hunt with a bit offered in the same cycle
    rx_en = 1'b1; rx_bit = 1'b1;
    do_hunt();
    rx_en = 1'b0;
    check(sync_ok == 1'b0, "R11", sync_ok, 0);
    first = 0;
    for (int i = 1; i <= 8; i++) begin
      send_bit(sync_b[i-1], h, vl);
      if (vl) first = 99;
      if (h && first == 0) first = i;
    end
    check(first == 8, "R11 restart", first, 8);

    // R11: hunt in the middle of a character gives no strobe
    send_bit(1'b1, h, vl);
    do_hunt();
    vl = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rx_char_vld) vl = 1'b1;
    end
    check(!vl && !sync_ok, "R11 mid-char", vl, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule